// File: doc/BRIEF.md
# Write-Back Three-State Snooping Cache Controller

This block is the cache controller of one node in a small shared-memory multiprocessor. It holds a direct-mapped, write-back cache of one-word lines. Each line is Invalid, Shared (clean and read-only) or Exclusive (the sole copy, writable and dirty). Processor reads and writes are served from the cache when the line state allows it. Otherwise the controller requests the shared bus and places a read-miss or write-miss transaction. Before the new line can be fetched, a dirty victim in the same slot is written back in its own transaction.

The bus is atomic: a granted transaction starts and finishes in one cycle. The controller watches every transaction on the bus. When another node misses on a line that this node holds Exclusive, the controller raises an abort line in that same cycle, drives its dirty word in place of memory and downgrades its copy. A write miss from another node also removes a Shared copy. Transactions that carry this node's own identifier are not snooped. A snoop in a cycle takes precedence over any processor access in that cycle.

Top module: `msi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, and no bus request, processor acknowledge or abort is raised while nothing is asked of the block.
- R2: A read whose address tag matches a Shared or Exclusive line is acknowledged in the same cycle with the stored word and raises no bus request.
- R3: A write whose tag matches an Exclusive line is acknowledged in the same cycle without a bus request, and the new word is stored.
- R4: A read that does not hit requests command 1 (read miss) at the full address. In the cycle the request is granted it is acknowledged with the bus read data, and the line becomes Shared with that word.
- R5: A write to an Invalid or Shared line, or to a line with another tag, requests command 2 (write miss) at the full address. In the cycle the request is granted it is acknowledged, and the line becomes Exclusive holding the written word.
- R6: When the addressed slot is Exclusive under a different tag, the controller first requests command 3 (write-back) carrying the victim's address and word, with no acknowledge. Only after that grant does it place the miss.
- R7: A snooped read miss (command 1) that matches an Exclusive line raises the abort in the same cycle and drives the line's word. The line becomes Shared.
- R8: A snooped write miss (command 2) that matches an Exclusive line raises the abort in the same cycle and drives the line's word. The line becomes Invalid.
- R9: A snooped write miss that matches a Shared line invalidates it without an abort. Snooped read misses on Shared lines, snooped write-backs and transactions whose tag does not match leave the cache unchanged and raise no abort.
- R10: A bus transaction whose source field equals the node's own identifier is not snooped: no abort, and no line changes.
- R11: In a cycle with a snooped transaction, a pending processor request is neither acknowledged nor allowed to raise a bus request. It is served in a later cycle.
- R12: Two addresses that share an index but differ in tag are told apart. An access whose tag does not match is handled as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor access pending, held until acknowledged |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write word |
| cpu_ack | output | 1 | Access completes in this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_ack on a read |
| breq_valid | output | 1 | Bus transaction requested |
| breq_cmd | output | 2 | Requested command: 1 read miss, 2 write miss, 3 write-back |
| breq_addr | output | ADDR_W | Requested transaction address |
| breq_data | output | DATA_W | Write-back word |
| bus_gnt | input | 1 | The requested transaction is on the bus this cycle |
| bus_valid | input | 1 | A transaction is on the bus |
| bus_src | input | NODE_W | Identifier of the issuing node |
| bus_cmd | input | 2 | Command on the bus, encoded as for breq_cmd |
| bus_addr | input | ADDR_W | Address on the bus |
| bus_rdata | input | DATA_W | Fill word returned for this node's miss |
| snp_abort | output | 1 | This node owns the snooped line; memory must not answer |
| snp_data | output | DATA_W | Dirty word supplied with snp_abort |

## Verification
The bench builds the controller with a 4-bit address, a 2-bit index, 8-bit data and node identifier 1. That gives 16 addresses folding onto 4 lines with four competing tags each, so conflict misses, dirty victims and tag mismatches come up all the time. Every address is first written and read back in turn. A long pseudo-random mix then interleaves reads, writes, foreign snoops of every command, snoops colliding with a pending processor request, and self-sourced transactions. The bench keeps its own state, tag, data and memory model, so every reachable state and command pairing is exercised.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WRBACK = 2'd3
  } bus_cmd_t;
endpackage

// File: rtl/msi_line_array.sv
module msi_line_array
  import msi_pkg::*;
#(
  parameter int INDEX_W = 6,
  parameter int TAG_W   = 10,
  parameter int DATA_W  = 32,
  localparam int NLINES = 1 << INDEX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [INDEX_W-1:0]     p_idx,
  output line_st_t               p_state,
  output logic [TAG_W-1:0]       p_tag,
  output logic [DATA_W-1:0]      p_data,
  input  logic [INDEX_W-1:0]     s_idx,
  output line_st_t               s_state,
  output logic [TAG_W-1:0]       s_tag,
  output logic [DATA_W-1:0]      s_data,
  output logic [NLINES-1:0][1:0] st_all,
  input  logic                   sw_en,
  input  line_st_t               sw_state,
  input  logic                   pw_en,
  input  line_st_t               pw_state,
  input  logic [TAG_W-1:0]       pw_tag,
  input  logic                   pw_data_en,
  input  logic [DATA_W-1:0]      pw_data
);
  line_st_t          st_q [NLINES];
  line_st_t          st_d [NLINES];
  logic [TAG_W-1:0]  tag_q [NLINES];
  logic [DATA_W-1:0] dat_q [NLINES];
  logic              pw_ok;

  // snoop update wins when both ports address the same slot
  assign pw_ok = pw_en && !(sw_en && (s_idx == p_idx));

  always_comb begin
    for (int i = 0; i < NLINES; i++) begin
      st_d[i] = st_q[i];
      if (sw_en && (s_idx == INDEX_W'(i)))      st_d[i] = sw_state;
      else if (pw_ok && (p_idx == INDEX_W'(i))) st_d[i] = pw_state;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) st_q[i] <= LN_INV;
    end else begin
      for (int i = 0; i < NLINES; i++) st_q[i] <= st_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (pw_ok)              tag_q[p_idx] <= pw_tag;
    if (pw_ok && pw_data_en) dat_q[p_idx] <= pw_data;
  end

  assign p_state = st_q[p_idx];
  assign p_tag   = tag_q[p_idx];
  assign p_data  = dat_q[p_idx];
  assign s_state = st_q[s_idx];
  assign s_tag   = tag_q[s_idx];
  assign s_data  = dat_q[s_idx];

  always_comb begin
    for (int i = 0; i < NLINES; i++) st_all[i] = st_q[i];
  end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int INDEX_W = 6,
  parameter int DATA_W  = 32,
  parameter int NODE_W  = 2,
  parameter int NODE_ID = 0,
  localparam int TAG_W  = ADDR_W - INDEX_W
) (
  input  logic               bus_valid,
  input  logic [NODE_W-1:0]  bus_src,
  input  logic [1:0]         bus_cmd,
  input  logic [ADDR_W-1:0]  bus_addr,
  output logic [INDEX_W-1:0] s_idx,
  input  line_st_t           s_state,
  input  logic [TAG_W-1:0]   s_tag,
  input  logic [DATA_W-1:0]  s_data,
  output logic               snoop_act,
  output logic               abort,
  output logic [DATA_W-1:0]  sdata,
  output logic               sw_en,
  output line_st_t           sw_state
);
  logic match;

  assign s_idx     = bus_addr[INDEX_W-1:0];
  assign snoop_act = bus_valid && (bus_src != NODE_W'(NODE_ID));
  assign match     = snoop_act && (s_state != LN_INV) &&
                     (s_tag == bus_addr[ADDR_W-1:INDEX_W]);

  always_comb begin
    abort    = 1'b0;
    sdata    = '0;
    sw_en    = 1'b0;
    sw_state = s_state;
    if (match) begin
      if (bus_cmd == BC_RDMISS && s_state == LN_EXC) begin
        abort    = 1'b1;
        sdata    = s_data;
        sw_en    = 1'b1;
        sw_state = LN_SHR;
      end else if (bus_cmd == BC_WRMISS) begin
        abort    = (s_state == LN_EXC);
        sdata    = (s_state == LN_EXC) ? s_data : '0;
        sw_en    = 1'b1;
        sw_state = LN_INV;
      end
    end
  end
endmodule

// File: rtl/msi_proc_ctrl.sv
module msi_proc_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int INDEX_W = 6,
  parameter int DATA_W  = 32,
  localparam int TAG_W  = ADDR_W - INDEX_W
) (
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  logic               snoop_act,
  input  logic               bus_gnt,
  input  logic [DATA_W-1:0]  bus_rdata,
  output logic [INDEX_W-1:0] p_idx,
  input  line_st_t           p_state,
  input  logic [TAG_W-1:0]   p_tag,
  input  logic [DATA_W-1:0]  p_data,
  output logic               cpu_ack,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               req_valid,
  output logic [1:0]         req_cmd,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [DATA_W-1:0]  req_data,
  output logic               pw_en,
  output line_st_t           pw_state,
  output logic [TAG_W-1:0]   pw_tag,
  output logic               pw_data_en,
  output logic [DATA_W-1:0]  pw_data
);
  logic [TAG_W-1:0] tag;
  logic go, hit, dirty_victim;

  assign p_idx        = cpu_addr[INDEX_W-1:0];
  assign tag          = cpu_addr[ADDR_W-1:INDEX_W];
  assign go           = cpu_req && !snoop_act;
  assign hit          = (p_state != LN_INV) && (p_tag == tag);
  assign dirty_victim = (p_state == LN_EXC) && (p_tag != tag);

  always_comb begin
    cpu_ack    = 1'b0;
    cpu_rdata  = '0;
    req_valid  = 1'b0;
    req_cmd    = BC_NONE;
    req_addr   = '0;
    req_data   = '0;
    pw_en      = 1'b0;
    pw_state   = p_state;
    pw_tag     = tag;
    pw_data_en = 1'b0;
    pw_data    = cpu_wdata;
    if (go) begin
      if (!cpu_we && hit) begin
        cpu_ack   = 1'b1;
        cpu_rdata = p_data;
      end else if (cpu_we && hit && p_state == LN_EXC) begin
        cpu_ack    = 1'b1;
        pw_en      = 1'b1;
        pw_state   = LN_EXC;
        pw_data_en = 1'b1;
      end else if (dirty_victim) begin
        req_valid = 1'b1;
        req_cmd   = BC_WRBACK;
        req_addr  = {p_tag, p_idx};
        req_data  = p_data;
        if (bus_gnt) begin
          pw_en    = 1'b1;
          pw_state = LN_INV;
          pw_tag   = p_tag;
        end
      end else begin
        req_valid = 1'b1;
        req_cmd   = cpu_we ? BC_WRMISS : BC_RDMISS;
        req_addr  = cpu_addr;
        if (bus_gnt) begin
          cpu_ack    = 1'b1;
          cpu_rdata  = cpu_we ? '0 : bus_rdata;
          pw_en      = 1'b1;
          pw_state   = cpu_we ? LN_EXC : LN_SHR;
          pw_data_en = 1'b1;
          pw_data    = cpu_we ? cpu_wdata : bus_rdata;
        end
      end
    end
  end
endmodule

// File: rtl/msi_snoop_cache.sv
module msi_snoop_cache
  import msi_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int INDEX_W = 6,
  parameter int DATA_W  = 32,
  parameter int NODE_W  = 2,
  parameter int NODE_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              breq_valid,
  output logic [1:0]        breq_cmd,
  output logic [ADDR_W-1:0] breq_addr,
  output logic [DATA_W-1:0] breq_data,
  input  logic              bus_gnt,
  input  logic              bus_valid,
  input  logic [NODE_W-1:0] bus_src,
  input  logic [1:0]        bus_cmd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              snp_abort,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W  = ADDR_W - INDEX_W;
  localparam int NLINES = 1 << INDEX_W;

  logic [1:0]             rst_sync;
  logic                   rst_q;
  logic [INDEX_W-1:0]     p_idx, s_idx;
  line_st_t               p_state, s_state, sw_state, pw_state;
  logic [TAG_W-1:0]       p_tag, s_tag, pw_tag;
  logic [DATA_W-1:0]      p_data, s_data, pw_data;
  logic [NLINES-1:0][1:0] st_all;
  logic                   snoop_act, sw_en, pw_en, pw_data_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  msi_line_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_q),
    .p_idx(p_idx), .p_state(p_state), .p_tag(p_tag), .p_data(p_data),
    .s_idx(s_idx), .s_state(s_state), .s_tag(s_tag), .s_data(s_data),
    .st_all(st_all),
    .sw_en(sw_en), .sw_state(sw_state),
    .pw_en(pw_en), .pw_state(pw_state), .pw_tag(pw_tag),
    .pw_data_en(pw_data_en), .pw_data(pw_data)
  );

  msi_snoop_ctrl #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W),
                   .NODE_W(NODE_W), .NODE_ID(NODE_ID)) u_snp (
    .bus_valid(bus_valid), .bus_src(bus_src), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .s_idx(s_idx), .s_state(s_state), .s_tag(s_tag), .s_data(s_data),
    .snoop_act(snoop_act), .abort(snp_abort), .sdata(snp_data),
    .sw_en(sw_en), .sw_state(sw_state)
  );

  msi_proc_ctrl #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_proc (
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .snoop_act(snoop_act), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .p_idx(p_idx), .p_state(p_state), .p_tag(p_tag), .p_data(p_data),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .req_valid(breq_valid), .req_cmd(breq_cmd), .req_addr(breq_addr), .req_data(breq_data),
    .pw_en(pw_en), .pw_state(pw_state), .pw_tag(pw_tag),
    .pw_data_en(pw_data_en), .pw_data(pw_data)
  );

  // R11: a foreign snoop cycle blocks the processor side entirely
  p_snoop_blocks_cpu_r11: assert property (@(posedge clk) disable iff (!rst_q)
    snoop_act |-> (!breq_valid && !cpu_ack));

  // R6: a write-back request only ever names a slot held Exclusive
  p_wb_from_owner_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (breq_valid && breq_cmd == BC_WRBACK) |-> (p_state == LN_EXC));

  // R5: a granted write miss leaves its slot Exclusive
  p_wrmiss_owns_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (breq_valid && bus_gnt && breq_cmd == BC_WRMISS) |=> (st_all[$past(p_idx)] == LN_EXC));

  // R4: a granted read miss leaves its slot Shared
  p_rdmiss_shared_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (breq_valid && bus_gnt && breq_cmd == BC_RDMISS) |=> (st_all[$past(p_idx)] == LN_SHR));

  // R7: supplying data for a foreign read miss downgrades to Shared
  p_abort_rd_shared_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (snp_abort && bus_cmd == BC_RDMISS) |=> (st_all[$past(s_idx)] == LN_SHR));

  // R8: supplying data for a foreign write miss invalidates
  p_abort_wr_inv_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (snp_abort && bus_cmd == BC_WRMISS) |=> (st_all[$past(s_idx)] == LN_INV));

  // R10: no abort for a transaction carrying this node's identifier
  p_own_src_quiet_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_valid && bus_src == NODE_W'(NODE_ID)) |-> !snp_abort);
endmodule

// File: tb/sim_msi_snoop_cache.sv
`timescale 1ns/1ps
module sim_msi_snoop_cache;
  localparam int AW = 4, IW = 2, DW = 8, NW = 2, ID = 1;
  localparam int NL = 1 << IW;
  localparam int NA = 1 << AW;

  logic clk, rst_n;
  logic cpu_req, cpu_we, cpu_ack;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic breq_valid;
  logic [1:0] breq_cmd;
  logic [AW-1:0] breq_addr;
  logic [DW-1:0] breq_data;
  logic bus_gnt, bus_valid;
  logic [NW-1:0] bus_src;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_rdata;
  logic snp_abort;
  logic [DW-1:0] snp_data;

  int n_chk = 0, n_fail = 0;
  int mst [NL];
  int mtg [NL];
  logic [DW-1:0] mdt [NL];
  logic [DW-1:0] mem [NA];
  logic [15:0] lfsr = 16'hACE1;

  msi_snoop_cache #(.ADDR_W(AW), .INDEX_W(IW), .DATA_W(DW), .NODE_W(NW), .NODE_ID(ID)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .breq_valid(breq_valid), .breq_cmd(breq_cmd), .breq_addr(breq_addr), .breq_data(breq_data),
    .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_src(bus_src), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .snp_abort(snp_abort), .snp_data(snp_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    bus_gnt = 0; bus_valid = 0; bus_src = '0; bus_cmd = 2'd0; bus_addr = '0; bus_rdata = '0;
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic cpu_op(input bit we, input int a, input logic [DW-1:0] d);
    int idx = a % NL;
    int tg  = a / NL;
    bit hit;
    string lbl;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = d;
    #1;
    hit = (mst[idx] != 0) && (mtg[idx] == tg);
    if (hit && (!we || mst[idx] == 2)) begin
      lbl = we ? "R3" : "R2";
      chk(!breq_valid, lbl, int'(breq_valid), 0);
      chk(cpu_ack, lbl, int'(cpu_ack), 1);
      if (!we) chk(cpu_rdata == mdt[idx], "R2", int'(cpu_rdata), int'(mdt[idx]));
      else mdt[idx] = d;
      @(posedge clk);
    end else begin
      if (mst[idx] == 2 && mtg[idx] != tg) begin
        int va = mtg[idx] * NL + idx;
        chk(breq_valid && breq_cmd == 2'd3, "R6", int'(breq_cmd), 3);
        chk(breq_addr == AW'(va), "R6", int'(breq_addr), va);
        chk(breq_data == mdt[idx], "R6", int'(breq_data), int'(mdt[idx]));
        bus_gnt = 1; bus_valid = 1; bus_src = NW'(ID); bus_cmd = 2'd3; bus_addr = AW'(va);
        #0.5;
        chk(!cpu_ack, "R6", int'(cpu_ack), 0);
        mem[va] = mdt[idx];
        mst[idx] = 0;
        @(posedge clk);
        @(negedge clk);
        bus_gnt = 0; bus_valid = 0;
        #1;
      end
      lbl = (mst[idx] != 0 && mtg[idx] != tg) ? "R12" : (we ? "R5" : "R4");
      chk(breq_valid && breq_cmd == (we ? 2'd2 : 2'd1), lbl, int'(breq_cmd), we ? 2 : 1);
      chk(breq_addr == AW'(a), lbl, int'(breq_addr), a);
      bus_gnt = 1; bus_valid = 1; bus_src = NW'(ID); bus_cmd = we ? 2'd2 : 2'd1;
      bus_addr = AW'(a); bus_rdata = mem[a];
      #0.5;
      chk(cpu_ack, lbl, int'(cpu_ack), 1);
      if (!we) chk(cpu_rdata == mem[a], "R4", int'(cpu_rdata), int'(mem[a]));
      mst[idx] = we ? 2 : 1;
      mtg[idx] = tg;
      mdt[idx] = we ? d : mem[a];
      @(posedge clk);
    end
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic snoop_op(input int cmd, input int a, input bit own, input bit with_cpu,
                          input logic [DW-1:0] nv);
    int idx = a % NL;
    int tg  = a / NL;
    bit match, expab;
    string lbl;
    @(negedge clk);
    bus_valid = 1; bus_src = own ? NW'(ID) : NW'(0); bus_cmd = 2'(cmd); bus_addr = AW'(a);
    if (with_cpu) begin
      cpu_req = 1; cpu_we = nv[0]; cpu_addr = AW'(nv); cpu_wdata = nv;
    end
    #1;
    match = !own && mst[idx] != 0 && mtg[idx] == tg;
    expab = match && mst[idx] == 2 && (cmd == 1 || cmd == 2);
    if (own) lbl = "R10";
    else if (match && mst[idx] == 2 && cmd == 1) lbl = "R7";
    else if (match && mst[idx] == 2 && cmd == 2) lbl = "R8";
    else lbl = "R9";
    chk(snp_abort == expab, lbl, int'(snp_abort), int'(expab));
    if (expab) chk(snp_data == mdt[idx], lbl, int'(snp_data), int'(mdt[idx]));
    if (with_cpu) begin
      chk(!cpu_ack, "R11", int'(cpu_ack), 0);
      chk(!breq_valid, "R11", int'(breq_valid), 0);
    end
    if (match && cmd == 1 && mst[idx] == 2) begin
      mem[a] = mdt[idx];
      mst[idx] = 1;
    end else if (match && cmd == 2) begin
      mst[idx] = 0;
    end
    if (!own && cmd == 2) mem[a] = nv;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    for (int i = 0; i < NL; i++) begin mst[i] = 0; mtg[i] = 0; mdt[i] = '0; end
    for (int i = 0; i < NA; i++) mem[i] = DW'(8'h30 + 7 * i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(!breq_valid, "R1", int'(breq_valid), 0);
    chk(!cpu_ack, "R1", int'(cpu_ack), 0);
    chk(!snp_abort, "R1", int'(snp_abort), 0);
    // R1: the first read of each slot must miss
    for (int i = 0; i < NL; i++) cpu_op(0, i, '0);
    // sweep: write then read every address
    for (int a = 0; a < NA; a++) begin
      cpu_op(1, a, DW'(8'hA0 + a));
      cpu_op(0, a, '0);
    end
    // mixed pseudo-random traffic
    for (int k = 0; k < 900; k++) begin
      int kind, a;
      step_lfsr();
      kind = int'(lfsr[2:0]);
      a = int'(lfsr[7:4]);
      case (kind)
        0, 1, 2: cpu_op(0, a, '0);
        3, 4:    cpu_op(1, a, lfsr[15:8]);
        5:       snoop_op(lfsr[8] ? 2 : (lfsr[9] ? 1 : 3), a, 0, 0, lfsr[15:8]);
        6:       snoop_op(lfsr[8] ? 2 : 1, a, 0, 1, lfsr[15:8]);
        default: snoop_op(lfsr[8] ? 2 : 1, a, 1, 0, lfsr[15:8]);
      endcase
    end
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule